// File: doc/BRIEF.md
# Stack Push, Call and Return Sequencer

This block is a small multi-cycle controller for the stack operations of a 16-bit processor core. It is given a 3-bit operation selector and a 16-bit operand together with a one-cycle start strobe. It then runs one of three stack sequences against a single-ported 16-bit word memory:

- **push** stores the operand on the stack;
- **subroutine call** saves the current program counter on the stack and jumps to the operand;
- **return-from-interrupt** pops the status word and then the program counter.

The block owns the stack pointer (SP), program counter (PC) and status register (SR) that these sequences use. A single-cycle done pulse marks the end of every sequence. The architectural registers change only on the clock edge that raises done, so a sequence in flight never exposes a partial result.

The memory port has an address, write data, a write enable and a read enable. Read data comes back exactly one cycle after the read address is presented. Selector values that do not name a stack operation finish at once with an illegal-operation flag and touch neither memory nor registers.

Top module: `stack_seq`

## Requirements
- R1: Selector 3'd4 is push, 3'd5 is call and 3'd6 is return-from-interrupt. Every other selector value (0 to 3 and 7) makes done and illegal high together in the first cycle after the start edge. In that case no memory read or write takes place and SP, PC and SR keep their values.
- R2: Push drives exactly one write cycle, in the first cycle after the start edge. The write uses address SP-2 and data equal to the operand. When done rises, SP reads SP-2.
- R3: Call drives exactly one write cycle, in the first cycle after the start edge. The write uses address SP-2 and data equal to the PC from before the call. When done rises, PC equals the operand and SP equals SP-2.
- R4: Return-from-interrupt reads address SP in the first cycle after the start edge and address SP+2 in the second. Read data is taken one cycle after each address. The first word becomes SR and the second becomes PC, and SP becomes SP+4.
- R5: Done is a single-cycle pulse. It comes in the second cycle after the start edge for push and call, and in the fourth cycle for return-from-interrupt. Busy is high from the first cycle after the start edge through the done cycle.
- R6: SP, PC and SR outputs change only in a cycle where done is high; they hold throughout a running sequence.
- R7: A start strobe that arrives while busy is high is ignored and does not alter the running sequence or its result.
- R8: Every memory address has bit 0 forced to zero. Write enable and read enable are never high in the same cycle, and both are low outside the access cycles.
- R9: After reset, SP equals parameter SP_RESET, PC and SR are zero, and done, busy, illegal, write enable and read enable are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, sampled when not busy |
| sel | input | 3 | Operation selector (instruction bits 9:7) |
| operand | input | 16 | Push data or call target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | High with done when the selector named no stack operation |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter |
| sr_out | output | 16 | Status register |
| mem_addr | output | 16 | Word address, bit 0 always zero |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the read address |

## Verification
The bench runs the sequencer with an odd reset stack pointer. This makes the bit-0 masking visible on every access, and a missing mask shows up as a wrong address.

Directed cases come first:
- a push followed by a call and a return, which must recover the pushed word as PC and the saved PC as SR, exposing any swap of the two pop reads;
- the illegal selectors 0 and 7;
- start strobes fired mid-sequence, which must leave the result unchanged.

A seeded random mix of all eight selector values and random operands then runs over randomly filled memory. A bench model of SP, PC and SR checks the address, data and register values in every cycle of each sequence, so an early commit or a wrong latency offset is reported.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD0,
        ST_RD1,
        ST_RD2,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_PUSH,
        OP_CALL,
        OP_RETI,
        OP_BAD
    } seq_op_e;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_PUSH = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CALL = 3'd5;
    localparam logic [SEL_W-1:0] SEL_RETI = 3'd6;

    function automatic seq_op_e decode_sel(input logic [SEL_W-1:0] s);
        seq_op_e r;
        case (s)
            SEL_PUSH: r = OP_PUSH;
            SEL_CALL: r = OP_CALL;
            SEL_RETI: r = OP_RETI;
            default:  r = OP_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stack_seq_agen.sv
module stack_seq_agen
    import stack_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  seq_state_e     state_i,
    input  logic [W-1:0]   sp_i,
    output logic [W-1:0]   addr_o,
    output logic [W-1:0]   sp_dec_o,
    output logic [W-1:0]   sp_inc4_o,
    output logic           we_o,
    output logic           re_o
);

    localparam logic [W-1:0] STEP       = W'(2);
    localparam logic [W-1:0] ALIGN_MASK = ~W'(1);

    logic [W-1:0] raw_addr;

    always_comb begin
        sp_dec_o  = sp_i - STEP;
        sp_inc4_o = sp_i + STEP + STEP;
        raw_addr  = '0;
        we_o      = 1'b0;
        re_o      = 1'b0;
        case (state_i)
            ST_WR: begin
                raw_addr = sp_dec_o;
                we_o     = 1'b1;
            end
            ST_RD0: begin
                raw_addr = sp_i;
                re_o     = 1'b1;
            end
            ST_RD1: begin
                raw_addr = sp_i + STEP;
                re_o     = 1'b1;
            end
            default: begin
                raw_addr = '0;
            end
        endcase
        addr_o = raw_addr & ALIGN_MASK;
    end

endmodule

// File: rtl/stack_seq_fsm.sv
module stack_seq_fsm
    import stack_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  sel_i,
    output seq_state_e        state_o,
    output seq_op_e           op_o,
    output logic              busy_o,
    output logic              done_o
);

    typedef struct packed {
        seq_state_e st;
        seq_op_e    op;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    fsm_d.op = decode_sel(sel_i);
                    case (fsm_d.op)
                        OP_PUSH, OP_CALL: fsm_d.st = ST_WR;
                        OP_RETI:          fsm_d.st = ST_RD0;
                        default:          fsm_d.st = ST_FIN;
                    endcase
                end
            end
            ST_WR:   fsm_d.st = ST_FIN;
            ST_RD0:  fsm_d.st = ST_RD1;
            ST_RD1:  fsm_d.st = ST_RD2;
            ST_RD2:  fsm_d.st = ST_FIN;
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st <= ST_IDLE;
            fsm_q.op <= OP_PUSH;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.st;
    assign op_o    = fsm_q.op;
    assign busy_o  = (fsm_q.st != ST_IDLE);
    assign done_o  = (fsm_q.st == ST_FIN);

    // R5: done lasts exactly one cycle
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a busy sequencer never restarts from idle on its own
    assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int          W        = 16,
    parameter logic [15:0] SP_RESET = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  sel,
    input  logic [W-1:0]      operand,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [W-1:0]      sp_out,
    output logic [W-1:0]      pc_out,
    output logic [W-1:0]      sr_out,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [W-1:0]      mem_rdata
);

    typedef struct packed {
        logic [W-1:0] sp;
        logic [W-1:0] pc;
        logic [W-1:0] sr;
        logic [W-1:0] opnd;
        logic [W-1:0] sr_hold;
        logic         bad;
    } arch_t;

    arch_t      arch_d, arch_q;
    seq_state_e state;
    seq_op_e    op;
    logic [W-1:0] sp_dec, sp_inc4;

    stack_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .sel_i   (sel),
        .state_o (state),
        .op_o    (op),
        .busy_o  (busy),
        .done_o  (done)
    );

    stack_seq_agen #(.W(W)) u_agen (
        .state_i   (state),
        .sp_i      (arch_q.sp),
        .addr_o    (mem_addr),
        .sp_dec_o  (sp_dec),
        .sp_inc4_o (sp_inc4),
        .we_o      (mem_we),
        .re_o      (mem_re)
    );

    always_comb begin
        arch_d = arch_q;
        if (start && !busy) begin
            arch_d.opnd = operand;
            arch_d.bad  = (decode_sel(sel) == OP_BAD);
        end
        case (state)
            ST_WR: begin
                arch_d.sp = sp_dec;
                if (op == OP_CALL) begin
                    arch_d.pc = arch_q.opnd;
                end
            end
            ST_RD1: begin
                arch_d.sr_hold = mem_rdata;
            end
            ST_RD2: begin
                arch_d.sr = arch_q.sr_hold;
                arch_d.pc = mem_rdata;
                arch_d.sp = sp_inc4;
            end
            default: begin
                arch_d.sp = arch_q.sp;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arch_q.sp      <= W'(SP_RESET);
            arch_q.pc      <= '0;
            arch_q.sr      <= '0;
            arch_q.opnd    <= '0;
            arch_q.sr_hold <= '0;
            arch_q.bad     <= 1'b0;
        end else begin
            arch_q <= arch_d;
        end
    end

    assign sp_out    = arch_q.sp;
    assign pc_out    = arch_q.pc;
    assign sr_out    = arch_q.sr;
    assign illegal   = done && arch_q.bad;
    assign mem_wdata = !mem_we ? '0 : ((op == OP_CALL) ? arch_q.pc : arch_q.opnd);

    // R2/R3: each write step leaves SP two lower
    assert_write_moves_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out == $past(sp_out) - W'(2)));

    // R3: a call jumps to the operand it was started with
    assert_call_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op == OP_CALL) |=> (pc_out == $past(arch_q.opnd)));

    // R4: the second pop read is followed by SP rising by four
    assert_pop_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD2) |=> (sp_out == $past(sp_out) + W'(4)));

    // R6: architectural state moves only with done
    assert_commit_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sp_out, pc_out, sr_out}) |-> done);

    // R1: an illegal selector finishes without any memory access
    assert_bad_no_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!$past(mem_we) && !$past(mem_re) && !mem_we && !mem_re));

    // R8: the port never reads and writes together
    assert_port_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

endmodule

// File: tb/stack_seq_tb.sv
`timescale 1ns/1ps
module stack_seq_tb;

    localparam logic [15:0] SP_INIT = 16'h0181;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [15:0] operand = 16'h0;
    logic        busy, done, illegal, mem_we, mem_re;
    logic [15:0] sp_out, pc_out, sr_out, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = 16'h0;

    logic [15:0] mem [0:255];

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] sp_m, pc_m, sr_m;

    always #10 clk = ~clk;

    stack_seq #(.W(16), .SP_RESET(SP_INIT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sel       (sel),
        .operand   (operand),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .sp_out    (sp_out),
        .pc_out    (pc_out),
        .sr_out    (sr_out),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[8:1]];
    end

    function automatic logic [15:0] al(input logic [15:0] a);
        return a & 16'hFFFE;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(req, "sp", sp_out, sp_m);
        check(req, "pc", pc_out, pc_m);
        check(req, "sr", sr_out, sr_m);
    endtask

    // one full sequence; poke fires a start strobe while busy (R7)
    task automatic run_op(input logic [2:0] s, input logic [15:0] v, input bit poke);
        logic [15:0] a0, a1, w0, w1;
        @(negedge clk);
        start = 1'b1; sel = s; operand = v;
        @(negedge clk);
        start = 1'b0;
        if (s == 3'd4 || s == 3'd5) begin
            a0 = al(sp_m - 16'd2);
            w0 = (s == 3'd4) ? v : pc_m;
            check("R2", "we", {15'd0, mem_we}, 16'd1);
            check("R8", "re", {15'd0, mem_re}, 16'd0);
            check((s == 3'd4) ? "R2" : "R3", "addr", mem_addr, a0);
            check((s == 3'd4) ? "R2" : "R3", "wdata", mem_wdata, w0);
            check("R6", "done early", {15'd0, done}, 16'd0);
            check("R5", "busy", {15'd0, busy}, 16'd1);
            check_regs("R6");
            if (poke) begin start = 1'b1; sel = 3'd6; operand = ~v; end
            @(negedge clk);
            start = 1'b0;
            sp_m = sp_m - 16'd2;
            if (s == 3'd5) pc_m = v;
            check("R5", "done", {15'd0, done}, 16'd1);
            check("R1", "illegal", {15'd0, illegal}, 16'd0);
            check("R8", "we idle", {15'd0, mem_we}, 16'd0);
            check_regs((s == 3'd4) ? "R2" : "R3");
            check((s == 3'd4) ? "R2" : "R3", "stored", mem[a0[8:1]], w0);
        end else if (s == 3'd6) begin
            a0 = al(sp_m);
            a1 = al(sp_m + 16'd2);
            w0 = mem[a0[8:1]];
            w1 = mem[a1[8:1]];
            check("R4", "re0", {15'd0, mem_re}, 16'd1);
            check("R8", "we0", {15'd0, mem_we}, 16'd0);
            check("R4", "addr0", mem_addr, a0);
            check_regs("R6");
            if (poke) begin start = 1'b1; sel = 3'd4; operand = ~v; end
            @(negedge clk);
            start = 1'b0;
            check("R4", "re1", {15'd0, mem_re}, 16'd1);
            check("R4", "addr1", mem_addr, a1);
            check("R6", "done early", {15'd0, done}, 16'd0);
            @(negedge clk);
            check("R8", "port idle", {14'd0, mem_we, mem_re}, 16'd0);
            check("R6", "done early", {15'd0, done}, 16'd0);
            check_regs("R6");
            @(negedge clk);
            sp_m = sp_m + 16'd4;
            sr_m = w0;
            pc_m = w1;
            check("R5", "done", {15'd0, done}, 16'd1);
            check("R1", "illegal", {15'd0, illegal}, 16'd0);
            check_regs("R4");
        end else begin
            check("R1", "done", {15'd0, done}, 16'd1);
            check("R1", "illegal", {15'd0, illegal}, 16'd1);
            check("R1", "no access", {14'd0, mem_we, mem_re}, 16'd0);
            check_regs("R1");
        end
        @(negedge clk);
        check("R5", "done pulse", {15'd0, done}, 16'd0);
        check("R5", "busy clear", {15'd0, busy}, 16'd0);
        check_regs("R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20211022));
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        sp_m = SP_INIT; pc_m = 16'h0; sr_m = 16'h0;
        repeat (3) @(negedge clk);
        check("R9", "sp", sp_out, SP_INIT);
        check("R9", "pc", pc_out, 16'h0);
        check("R9", "sr", sr_out, 16'h0);
        check("R9", "flags", {11'd0, done, busy, illegal, mem_we, mem_re}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "idle", {14'd0, done, busy}, 16'd0);

        // directed
        run_op(3'd4, 16'hBEEF, 1'b0);
        run_op(3'd5, 16'h4000, 1'b0);
        run_op(3'd6, 16'h0000, 1'b0);
        run_op(3'd7, 16'h1234, 1'b0);
        run_op(3'd0, 16'h5678, 1'b0);
        run_op(3'd4, 16'h0F0F, 1'b1);
        run_op(3'd5, 16'h8002, 1'b1);
        run_op(3'd6, 16'hFFFF, 1'b1);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [2:0] s;
            s = 3'($urandom % 8);
            run_op(s, 16'($urandom), 1'($urandom % 2));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule